// File: doc/BRIEF.md
# Zero-Cross Synchronized Stereo Gain Updater

This block keeps the active input-gain setting for a stereo channel pair. It accepts writes of an 8-bit control byte. Bit 7 of the byte selects zero-cross synchronisation, and bits 6..0 carry a 7-bit gain code. When synchronisation is off, a write changes both channels at once. When it is on, the write only arms a pending code. Each channel then moves to that code at its own next zero crossing, or when a sample-count timeout runs out, whichever comes first. The two channels do not wait for each other.

Samples arrive as signed left and right words qualified by a sample strobe. For each channel the block outputs four things: the active gain code, a pending flag, a mute flag, and the gain expressed as a signed count of half-decibel steps. The code-to-gain mapping is piecewise. The step is fine near unity gain and grows coarser towards the bottom of the range.

Top module: `zc_gain_updater`

## Requirements
- R1: After reset both active codes are 0x28, the gain outputs are 0, and the pending and mute flags are 0.
- R2: A write with bit 7 = 0 puts the clamped code into both active codes on the clock after the write and clears both pending flags.
- R3: A write with bit 7 = 1 raises both pending flags on the next clock and leaves the active codes unchanged until each channel's own trigger.
- R4: While pending, a channel adopts the pending code when a strobed sample's sign bit differs from that of the previous strobed sample, or when the sample is exactly zero. The new code and the cleared flag appear on the next clock.
- R5: The left and right channels apply a pending code independently. A crossing on one channel does not affect the other.
- R6: If no crossing occurs, a pending channel applies its code on the (256 << to_sel)-th strobed sample after the write. So to_sel = 0 gives 256 samples and to_sel = 3 gives 2048.
- R7: A new write while a change is pending replaces the pending code and restarts the timeout count.
- R8: The gain output in half-dB units is code−40 for codes 25..96, 2·code−64 for 17..24, 4·code−96 for 5..16, and 8·code−112 for 1..4. Code 0x60 is therefore +56 (+28 dB) and code 0x01 is −104 (−52 dB).
- R9: Code 0 raises the mute flag and gives gain −128. Written codes above 0x60 are clamped to 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Bit 7 zero-cross enable, bits 6..0 gain code |
| to_sel | input | 2 | Timeout select, 256 << to_sel samples |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | 16 | Signed left sample |
| smp_right | input | 16 | Signed right sample |
| gain_code_l | output | 7 | Active left gain code |
| gain_code_r | output | 7 | Active right gain code |
| gain_hdb_l | output | 8 | Signed left gain, half-dB units |
| gain_hdb_r | output | 8 | Signed right gain, half-dB units |
| mute_l | output | 1 | Left mute |
| mute_r | output | 1 | Right mute |
| pend_l | output | 1 | Left change pending |
| pend_r | output | 1 | Right change pending |

## Verification
The assertions check several properties on every cycle:
- an immediate write lands on both channels one clock later;
- an armed write raises both pending flags;
- an active code stays put while pending and no sample or write arrives;
- codes never exceed 0x60;
- mute and unity gain agree with the code.

Some behaviours can only be shown by the bench's scenarios. These are the full code-to-gain table, the per-channel choice of crossing instant, the exact sample count of each timeout setting, and the restart of that count by a second write.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
   localparam int UNITY_CODE = 40;
   localparam int TOP_CODE   = 96;

   function automatic int clamp_code(input int c);
      return (c > TOP_CODE) ? TOP_CODE : c;
   endfunction

   function automatic int code_hdb(input int c);
      if (c >= 25)      return c - UNITY_CODE;
      else if (c >= 17) return 2 * c - 64;
      else if (c >= 5)  return 4 * c - 96;
      else              return 8 * c - 112;
   endfunction
endpackage

// File: rtl/zcg_code_map.sv
module zcg_code_map #(
   parameter int CODE_W = 7,
   parameter int GAIN_W = 8
) (
   input  logic [CODE_W-1:0]        code,
   output logic signed [GAIN_W-1:0] hdb,
   output logic                     mute
);
   import zcg_pkg::*;
   localparam int MIN_GAIN = -(1 << (GAIN_W - 1));

   always_comb begin
      mute = (code == '0);
      if (mute) hdb = GAIN_W'(MIN_GAIN);
      else      hdb = GAIN_W'(code_hdb(int'(code)));
   end
endmodule

// File: rtl/zcg_channel.sv
module zcg_channel #(
   parameter int SAMPLE_W     = 16,
   parameter int CODE_W       = 7,
   parameter int TO_SEL_W     = 2,
   parameter int TO_BASE_LOG2 = 8,
   parameter int RESET_CODE   = 40,
   parameter bit ZERO_COUNTS  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_zc,
   input  logic [CODE_W-1:0]   wr_code,
   input  logic [TO_SEL_W-1:0] to_sel,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp,
   output logic [CODE_W-1:0]   code_o,
   output logic                pend_o
);
   localparam int CNT_W = TO_BASE_LOG2 + (1 << TO_SEL_W) - 1;

   logic [CODE_W-1:0] pend_code;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  limit_m1;
   logic              prev_sign;
   logic              zc_hit;
   logic              sign_flip;

   assign sign_flip = smp[SAMPLE_W-1] != prev_sign;
   assign limit_m1  = (CNT_W'(1) << (TO_BASE_LOG2 + int'(to_sel))) - CNT_W'(1);

   generate
      if (ZERO_COUNTS) begin : g_zero_hit
         assign zc_hit = sign_flip || (smp == '0);
      end else begin : g_flip_only
         assign zc_hit = sign_flip;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sign <= 1'b0;
      end else if (smp_valid) begin
         prev_sign <= smp[SAMPLE_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o    <= CODE_W'(RESET_CODE);
         pend_code <= CODE_W'(RESET_CODE);
         pend_o    <= 1'b0;
         cnt       <= '0;
      end else if (wr_en) begin
         cnt       <= '0;
         pend_code <= wr_code;
         if (wr_zc) begin
            pend_o <= 1'b1;
         end else begin
            pend_o <= 1'b0;
            code_o <= wr_code;
         end
      end else if (pend_o && smp_valid) begin
         if (zc_hit || cnt == limit_m1) begin
            code_o <= pend_code;
            pend_o <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater #(
   parameter int SAMPLE_W     = 16,
   parameter int CODE_W       = 7,
   parameter int GAIN_W       = 8,
   parameter int TO_SEL_W     = 2,
   parameter int TO_BASE_LOG2 = 8,
   parameter bit ZERO_COUNTS  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [CODE_W:0]          wr_data,
   input  logic [TO_SEL_W-1:0]      to_sel,
   input  logic                     smp_valid,
   input  logic [SAMPLE_W-1:0]      smp_left,
   input  logic [SAMPLE_W-1:0]      smp_right,
   output logic [CODE_W-1:0]        gain_code_l,
   output logic [CODE_W-1:0]        gain_code_r,
   output logic signed [GAIN_W-1:0] gain_hdb_l,
   output logic signed [GAIN_W-1:0] gain_hdb_r,
   output logic                     mute_l,
   output logic                     mute_r,
   output logic                     pend_l,
   output logic                     pend_r
);
   import zcg_pkg::*;
   localparam int NCH = 2;

   generate
      if (CODE_W < 7) begin : g_bad_code
         $error("CODE_W must hold code 0x60");
      end
      if (GAIN_W < 8) begin : g_bad_gain
         $error("GAIN_W must hold -128..+56");
      end
      if (SAMPLE_W < 2) begin : g_bad_smp
         $error("SAMPLE_W too small");
      end
   endgenerate

   logic [CODE_W-1:0]        wr_code;
   logic [SAMPLE_W-1:0]      smp_arr  [NCH];
   logic [CODE_W-1:0]        code_arr [NCH];
   logic                     pend_arr [NCH];
   logic signed [GAIN_W-1:0] hdb_arr  [NCH];
   logic                     mute_arr [NCH];

   assign wr_code    = CODE_W'(clamp_code(int'(wr_data[CODE_W-1:0])));
   assign smp_arr[0] = smp_left;
   assign smp_arr[1] = smp_right;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         zcg_channel #(
            .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .TO_SEL_W(TO_SEL_W),
            .TO_BASE_LOG2(TO_BASE_LOG2), .RESET_CODE(UNITY_CODE),
            .ZERO_COUNTS(ZERO_COUNTS)
         ) u_chan (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_zc(wr_data[CODE_W]),
            .wr_code(wr_code), .to_sel(to_sel), .smp_valid(smp_valid),
            .smp(smp_arr[ch]), .code_o(code_arr[ch]), .pend_o(pend_arr[ch])
         );
         zcg_code_map #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_map (
            .code(code_arr[ch]), .hdb(hdb_arr[ch]), .mute(mute_arr[ch])
         );
      end
   endgenerate

   assign gain_code_l = code_arr[0];
   assign gain_code_r = code_arr[1];
   assign pend_l      = pend_arr[0];
   assign pend_r      = pend_arr[1];
   assign gain_hdb_l  = hdb_arr[0];
   assign gain_hdb_r  = hdb_arr[1];
   assign mute_l      = mute_arr[0];
   assign mute_r      = mute_arr[1];
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker #(
   parameter int CODE_W = 7,
   parameter int GAIN_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [CODE_W:0]          wr_data,
   input logic                     smp_valid,
   input logic [CODE_W-1:0]        gain_code_l,
   input logic [CODE_W-1:0]        gain_code_r,
   input logic signed [GAIN_W-1:0] gain_hdb_l,
   input logic                     mute_l,
   input logic                     mute_r,
   input logic                     pend_l,
   input logic                     pend_r
);
   p_direct_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_data[CODE_W] |=> !pend_l && !pend_r && gain_code_l == gain_code_r &&
      gain_code_l == (($past(wr_data[CODE_W-1:0]) > 7'd96) ? 7'd96 : $past(wr_data[CODE_W-1:0])));

   p_arm_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[CODE_W] |=> pend_l && pend_r);

   p_hold_while_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_l && !wr_en && !smp_valid |=> $stable(gain_code_l) && pend_l);

   p_code_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gain_code_l <= 7'd96 && gain_code_r <= 7'd96);

   p_mute_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mute_l |-> gain_hdb_l == -GAIN_W'(128) && gain_code_l == '0);

   p_mute_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mute_r |-> gain_code_r == '0);

   p_unity_gain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gain_code_l == 7'd40 |-> gain_hdb_l == '0);
endmodule

bind zc_gain_updater zcg_checker #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_chk (.*);

// File: tb/zc_gain_updater_test.sv
module zc_gain_updater_test;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [7:0]        wr_data = '0;
   logic [1:0]        to_sel = '0;
   logic              smp_valid = 1'b0;
   logic [15:0]       smp_left = '0;
   logic [15:0]       smp_right = '0;
   logic [6:0]        gain_code_l, gain_code_r;
   logic signed [7:0] gain_hdb_l, gain_hdb_r;
   logic              mute_l, mute_r, pend_l, pend_r;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   zc_gain_updater uut (.*);

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ref_gain(input int c);
      int h;
      if (c == 0) return -128;
      h = 56;
      for (int k = 96; k > c; k--) h -= (k > 24) ? 1 : (k > 16) ? 2 : (k > 4) ? 4 : 8;
      return h;
   endfunction

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic smp(input int l, input int r);
      smp_valid = 1'b1; smp_left = 16'(l); smp_right = 16'(r);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(gain_code_l, 40, "R1 code_l"); chk(gain_code_r, 40, "R1 code_r");
      chk(gain_hdb_l, 0, "R1 hdb_l");    chk(pend_l, 0, "R1 pend_l");
      chk(mute_l, 0, "R1 mute_l");
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R8 R9 sweep every code with immediate writes
      for (int c = 0; c < 128; c++) begin
         int e;
         e = (c > 96) ? 96 : c;
         wr({1'b0, 7'(c)});
         chk(gain_code_l, e, "R2 code_l"); chk(gain_code_r, e, "R2 code_r");
         chk(gain_hdb_l, ref_gain(e), "R8 hdb_l");
         chk(gain_hdb_r, ref_gain(e), "R8 hdb_r");
         chk(mute_l, (e == 0) ? 1 : 0, "R9 mute_l");
         chk(mute_r, (e == 0) ? 1 : 0, "R9 mute_r");
      end

      // R3 R4 R5 independent zero crossings
      wr(8'h28);
      smp(100, 100);
      wr(8'hB0);
      chk(pend_l, 1, "R3 pend_l"); chk(pend_r, 1, "R3 pend_r");
      chk(gain_code_l, 40, "R3 hold_l");
      smp(200, 300);
      chk(pend_l, 1, "R4 no flip"); chk(gain_code_l, 40, "R4 no flip code");
      smp(-5, 7);
      chk(gain_code_l, 48, "R4 left flip"); chk(pend_l, 0, "R4 left pend");
      chk(gain_code_r, 40, "R5 right held"); chk(pend_r, 1, "R5 right pend");
      smp(-9, 0);
      chk(gain_code_r, 48, "R4 right zero"); chk(pend_r, 0, "R4 right pend");

      // R6 timeout, to_sel = 0 (256 samples)
      to_sel = 2'd0;
      smp(1000, 1000);
      wr(8'h90);
      for (int i = 0; i < 255; i++) smp(1000, 1000);
      chk(pend_l, 1, "R6 before 256"); chk(gain_code_l, 48, "R6 before code");
      smp(1000, 1000);
      chk(pend_l, 0, "R6 at 256"); chk(gain_code_l, 16, "R6 code_l");
      chk(gain_code_r, 16, "R6 code_r");

      // R7 rewrite replaces code and restarts timeout
      wr(8'hA0);
      for (int i = 0; i < 100; i++) smp(1000, 1000);
      wr(8'hC4);
      for (int i = 0; i < 255; i++) smp(1000, 1000);
      chk(pend_l, 1, "R7 restarted"); chk(gain_code_l, 16, "R7 old code");
      smp(1000, 1000);
      chk(gain_code_l, 68, "R7 newest code"); chk(pend_r, 0, "R7 pend_r");

      // R6 timeout, to_sel = 3 (2048 samples)
      to_sel = 2'd3;
      wr(8'h81);
      for (int i = 0; i < 2047; i++) smp(1000, 1000);
      chk(pend_l, 1, "R6 before 2048");
      smp(1000, 1000);
      chk(pend_l, 0, "R6 at 2048"); chk(gain_code_l, 1, "R6 code 2048");
      chk(gain_hdb_l, -104, "R8 floor");

      finish_run();
   end
endmodule